// File: doc/BRIEF.md
# XOR-Coded Contention Output Port with Link Decoder

This block is one output port of a switch that sends flits without waiting for arbitration. When only one input asks for the port, that input's flit goes onto the link in the same cycle and the input is acknowledged at once. When two or more inputs ask at the same time, the port does not stall. It sends the bitwise XOR of every contending flit that has not yet been served, and in that same cycle a round-robin arbiter picks one contender to acknowledge. On the next cycle the winner is left out of the mix. This repeats until one flit remains, and that last flit goes out uncoded.

A group of k contenders therefore takes k link cycles, and no cycle is left idle. The link carries a coded flag and a count of the words still to come in the group. The decoder on the receive side keeps the last word it received. It emits nothing on the first coded word of a group. On each later word it emits the XOR of the stored word and the new one. On the final uncoded word it also emits the word itself on a second lane. Flits come out in the order the sending arbiter served them. Only head flits are expected to collide this way, because body flits follow the connection their head has locked. Routing happens elsewhere.

Top module: `xcode_link`

## Requirements
- R1: After reset, and while no input requests, link_vld, in_gnt, dec_vld and dec_tail_vld are all 0.
- R2: If exactly one input is valid and no group is in progress, link_flit equals that input's flit in the same cycle. In that case link_coded=0, link_left=0, in_gnt acknowledges that input, and dec_vld=1 with dec_flit equal to the flit.
- R3: In a cycle where m≥2 unserved members remain, link_flit is the XOR of their flits, link_coded=1 and link_left=m-1.
- R4: Each link word acknowledges exactly one member of the current set through in_gnt, a one-hot vector. That input is left out of every later word of the group.
- R5: The arbiter serves the first member found by searching upward in index from the position just after the last input it served, wrapping from N-1 to 0. After reset the search starts at index 0.
- R6: Once a group has started, an input that becomes valid later is neither mixed in nor acknowledged until the group's final word has passed. After that it is served as a new request.
- R7: The decoder emits nothing on the first coded word of a group. On each following word of the group, dec_flit carries the flit that was acknowledged on the previous link word.
- R8: On a group's final, uncoded word, dec_flit carries the flit served on the previous word, and dec_tail_vld=1 with dec_tail_flit equal to the final flit. The flits are recovered in grant order.
- R9: A requesting input holds in_vld and its flit steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | N | Per-input request (head flit present) |
| in_flit | input | N*W | Per-input flit, input i at bits [i*W +: W] |
| in_gnt | output | N | Per-input acknowledge, one-hot when set |
| link_vld | output | 1 | Link word present |
| link_coded | output | 1 | Link word is an XOR mixture of two or more flits |
| link_left | output | $clog2(N+1) | Words still to follow in the current group |
| link_flit | output | W | Link word |
| dec_vld | output | 1 | Decoded flit on the main lane |
| dec_flit | output | W | Decoded flit |
| dec_tail_vld | output | 1 | Final flit of a group on the second lane |
| dec_tail_flit | output | W | Final flit of a group |

## Verification
Two things can happen in the same cycle. The arbiter is consuming the tail of a group, and a new request is arriving. The bench provokes this by raising an outside input on the second word of a group. It then checks that this input stays out of the XOR and gets no acknowledge until the group's final word is done, and that it is served alone on the very next cycle. The decoder's two lanes also fire together on that final word, so every group is checked lane by lane against the grant order that an arithmetic round-robin model in the bench predicts.

// File: rtl/xcode_pkg.sv
package xcode_pkg;

   // Decoder state: outside a group, or inside one holding the previous word
   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_MIX  = 1'b1
   } xc_rx_e;

endpackage

// File: rtl/xcode_rr_arb.sv
module xcode_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("xcode_rr_arb: N must be at least 2");
   end

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win_idx;
   logic          found;

   always_comb begin
      gnt     = '0;
      win_idx = '0;
      found   = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % N;
         if (!found && req[idx]) begin
            found       = 1'b1;
            gnt[idx]    = 1'b1;
            win_idx     = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv && found) begin
         ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + IW'(1);
      end
   end

   // R4: a grant only ever goes to a requester, one at a time
   p_gnt_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~req) == '0));

   // R5: any request at all yields a grant
   p_req_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> $onehot(gnt));

endmodule

// File: rtl/xcode_mixer.sv
module xcode_mixer #(
   parameter int N    = 4,
   parameter int W    = 8,
   parameter int CNTW = $clog2(N + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    in_vld,
   input  logic [N*W-1:0]  in_flit,
   output logic [N-1:0]    in_gnt,
   output logic            link_vld,
   output logic            link_coded,
   output logic [CNTW-1:0] link_left,
   output logic [W-1:0]    link_flit
);
   if (W < 1) begin : g_bad_w
      $error("xcode_mixer: W must be at least 1");
   end
   if (CNTW < $clog2(N + 1)) begin : g_bad_cntw
      $error("xcode_mixer: CNTW too narrow for N");
   end

   logic [N-1:0]    rem_q;     // unserved members of an open group
   logic [N-1:0]    cur;       // members contributing to this word
   logic [CNTW-1:0] cnt;
   logic [W-1:0]    lane_flit [N];
   logic [W-1:0]    mix;

   // New requests only open a group when none is pending
   assign cur = (|rem_q) ? rem_q : in_vld;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign lane_flit[i] = cur[i] ? in_flit[i*W +: W] : '0;
   end

   always_comb begin
      mix = '0;
      cnt = '0;
      for (int i = 0; i < N; i++) begin
         mix = mix ^ lane_flit[i];
         cnt = cnt + CNTW'(cur[i]);
      end
   end

   xcode_rr_arb #(.N(N)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cur),
      .adv   (link_vld),
      .gnt   (in_gnt)
   );

   assign link_vld   = |cur;
   assign link_coded = (cnt > CNTW'(1));
   assign link_left  = link_vld ? cnt - CNTW'(1) : '0;
   assign link_flit  = mix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else begin
         rem_q <= cur & ~in_gnt;
      end
   end

   // R9: members of an open group keep requesting until served
   p_members_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q & ~in_vld) == '0);

   // R3: each coded word is followed by one with exactly one fewer member
   p_left_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_vld && link_coded) |=>
         (link_vld && link_left == $past(link_left) - CNTW'(1)));

   // R4: a served input never reappears in the same group
   p_winner_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_vld && link_coded) |=> ((in_gnt & $past(in_gnt)) == '0));

   // R6: a word is acknowledged iff it is sent
   p_gnt_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      link_vld == (|in_gnt));

endmodule

// File: rtl/xcode_rx.sv
module xcode_rx
   import xcode_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         link_vld,
   input  logic         link_coded,
   input  logic [W-1:0] link_flit,
   output logic         dec_vld,
   output logic [W-1:0] dec_flit,
   output logic         dec_tail_vld,
   output logic [W-1:0] dec_tail_flit
);
   xc_rx_e       st_q;
   logic [W-1:0] prev_q;

   always_comb begin
      dec_vld       = 1'b0;
      dec_flit      = '0;
      dec_tail_vld  = 1'b0;
      dec_tail_flit = '0;
      if (link_vld) begin
         if (st_q == RX_MIX) begin
            dec_vld  = 1'b1;
            dec_flit = prev_q ^ link_flit;
            if (!link_coded) begin
               dec_tail_vld  = 1'b1;
               dec_tail_flit = link_flit;
            end
         end else if (!link_coded) begin
            dec_vld  = 1'b1;
            dec_flit = link_flit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         prev_q <= '0;
      end else if (link_vld) begin
         prev_q <= link_flit;
         st_q   <= link_coded ? RX_MIX : RX_IDLE;
      end
   end

   // R8: the second lane only fires alongside the main lane
   p_tail_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_tail_vld |-> dec_vld);

   // R7: a group never ends without a word on the link
   p_group_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_MIX) |-> link_vld);

endmodule

// File: rtl/xcode_link.sv
module xcode_link #(
   parameter int N = 4,
   parameter int W = 8,
   localparam int CNTW = $clog2(N + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    in_vld,
   input  logic [N*W-1:0]  in_flit,
   output logic [N-1:0]    in_gnt,
   output logic            link_vld,
   output logic            link_coded,
   output logic [CNTW-1:0] link_left,
   output logic [W-1:0]    link_flit,
   output logic            dec_vld,
   output logic [W-1:0]    dec_flit,
   output logic            dec_tail_vld,
   output logic [W-1:0]    dec_tail_flit
);
   if (N < 2 || N > 64) begin : g_bad_n
      $error("xcode_link: N must lie in 2..64");
   end

   xcode_mixer #(.N(N), .W(W), .CNTW(CNTW)) u_mix (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_vld     (in_vld),
      .in_flit    (in_flit),
      .in_gnt     (in_gnt),
      .link_vld   (link_vld),
      .link_coded (link_coded),
      .link_left  (link_left),
      .link_flit  (link_flit)
   );

   xcode_rx #(.W(W)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .link_vld      (link_vld),
      .link_coded    (link_coded),
      .link_flit     (link_flit),
      .dec_vld       (dec_vld),
      .dec_flit      (dec_flit),
      .dec_tail_vld  (dec_tail_vld),
      .dec_tail_flit (dec_tail_flit)
   );

   // R1: nothing decoded while the link is silent
   p_quiet_link_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !link_vld |-> (!dec_vld && !dec_tail_vld && in_gnt == '0));

endmodule

// File: tb/sim_xcode_link.sv
`timescale 1ns/1ps
module sim_xcode_link;
   localparam int N = 4;
   localparam int W = 8;
   localparam int CNTW = $clog2(N + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    in_vld = '0;
   logic [N*W-1:0]  in_flit = '0;
   logic [N-1:0]    in_gnt;
   logic            link_vld, link_coded;
   logic [CNTW-1:0] link_left;
   logic [W-1:0]    link_flit;
   logic            dec_vld, dec_tail_vld;
   logic [W-1:0]    dec_flit, dec_tail_flit;

   int checks = 0;
   int fails  = 0;
   int mptr   = 0;       // bench model of the round-robin position
   bit done   = 0;

   always #2 clk = ~clk;

   xcode_link #(.N(N), .W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
      .in_gnt(in_gnt), .link_vld(link_vld), .link_coded(link_coded),
      .link_left(link_left), .link_flit(link_flit),
      .dec_vld(dec_vld), .dec_flit(dec_flit),
      .dec_tail_vld(dec_tail_vld), .dec_tail_flit(dec_tail_flit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] fval(input int i, input int seed);
      return W'((i * 53 + seed * 29 + 7) & 8'hFF);
   endfunction

   function automatic int pick(input logic [N-1:0] set);
      for (int k = 0; k < N; k++) begin
         if (set[(mptr + k) % N]) return (mptr + k) % N;
      end
      return -1;
   endfunction

   // Run one contention group; 'late' (or -1) joins on the second word
   task automatic run_group(input logic [N-1:0] set, input int seed, input int late);
      logic [N-1:0] rem;
      logic [W-1:0] exp_x;
      logic [W-1:0] prev_w;
      int m, w, word;
      rem = set;
      word = 0;
      prev_w = '0;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         in_flit[i*W +: W] = fval(i, seed);
         if (set[i]) in_vld[i] = 1'b1;
      end
      while (rem != '0) begin
         if (word == 1 && late >= 0) in_vld[late] = 1'b1;
         #1;
         m = $countones(rem);
         exp_x = '0;
         for (int i = 0; i < N; i++) if (rem[i]) exp_x ^= fval(i, seed);
         w = pick(rem);
         chk(m > 1 ? "R3 mix" : "R2 plain", {24'd0, link_flit}, {24'd0, exp_x});
         chk("R3 coded", {31'd0, link_coded}, {31'd0, m > 1});
         chk("R3 left", 32'(link_left), 32'(m - 1));
         chk("R5 R6 grant", 32'(in_gnt), 32'(1 << w));
         if (word == 0 && m > 1) begin
            chk("R7 silent first", {31'd0, dec_vld}, 32'd0);
         end else if (word == 0) begin
            chk("R2 dec", {23'd0, dec_vld, dec_flit}, {23'd1, fval(w, seed)});
         end else begin
            chk("R7 dec", {23'd0, dec_vld, dec_flit}, {23'd1, prev_w});
         end
         if (m == 1 && word > 0)
            chk("R8 tail", {23'd0, dec_tail_vld, dec_tail_flit}, {23'd1, fval(w, seed)});
         else
            chk("R8 no tail", {31'd0, dec_tail_vld}, 32'd0);
         prev_w = fval(w, seed);
         rem[w] = 1'b0;
         mptr = (w + 1) % N;
         word++;
         @(negedge clk);
         in_vld[w] = 1'b0;
      end
      if (late >= 0) begin
         #1;
         chk("R6 late solo", {23'd0, link_vld, link_flit}, {23'd1, fval(late, seed)});
         chk("R6 late grant", 32'(in_gnt), 32'(1 << late));
         mptr = (late + 1) % N;
         @(negedge clk);
         in_vld[late] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset link", {30'd0, link_vld, |in_gnt}, 32'd0);
      chk("R1 reset dec", {30'd0, dec_vld, dec_tail_vld}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 idle", {29'd0, link_vld, dec_vld, dec_tail_vld}, 32'd0);
      for (int pass = 0; pass < 3; pass++) begin
         for (int s = 1; s < (1 << N); s++) begin
            run_group(N'(s), s + pass * 16, -1);
         end
      end
      run_group(4'b0011, 90, 2);
      run_group(4'b1101, 91, 1);
      run_group(4'b0110, 92, 0);
      @(negedge clk);
      #1;
      chk("R1 idle after", {29'd0, link_vld, dec_vld, dec_tail_vld}, 32'd0);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule